// File: doc/BRIEF.md
# Serial ADC Slave Model

This block stands in for a 12-bit two-channel serial converter on the far side of a three-wire serial link. It lets a controller design be tested in loopback with no external part. The model runs on a fast system clock and oversamples the chip-select, serial-clock and data-in lines. It hunts for a start bit and decodes a two-bit command: an input mode and a channel select. It then captures the channel values at the end of the acquisition window and returns the conversion result on data-out.

The analog levels are unsigned digital words, one per channel. The reference voltage corresponds to the value 2^REF_LOG2. The input words are wider than that, so they can go beyond full scale. In single-ended mode the selected channel is converted against ground. In pseudo-differential mode the channel bit chooses which input is the positive leg and which is the negative leg. The result is clamped to zero at the low end and to all-ones at the high end. The decoded command is held on debug outputs so that a bench can confirm what was received.

Top module: `adc_slave_model`

## Requirements
- R1: While chip select (active low) is high, data-out is not driven (`miso_oe` = 0, `miso` = 0). After reset, `dbg_cmd_valid` is 0.
- R2: Once data-out is driven, `miso` changes only after a falling edge of the serial clock. It never changes during the high phase.
- R3: After chip select falls, rising edges with data-in at 0 are ignored. The first rising edge with data-in at 1 is the start bit. The next rising edge captures the mode bit (1 = single-ended, 0 = pseudo-differential), and the one after that captures the channel bit. `dbg_single` and `dbg_chan` report the two bits and `dbg_cmd_valid` goes high. All three are kept until the next chip-select fall.
- R4: The acquisition window opens on the rising edge that carries the channel bit. The channel words are captured on the falling edge that follows the next rising edge. A change before that edge is converted, and a change after it is not.
- R5: On the falling edge that ends acquisition, data-out becomes driven with a null bit of 0. The next 12 falling edges present the result, most significant bit first.
- R6: In single-ended mode, channel bit 0 selects channel 0 and 1 selects channel 1. The code is floor(in × 4096 / 2^REF_LOG2), clamped to FFFh.
- R7: In pseudo-differential mode, channel bit 0 makes channel 0 the positive input and channel 1 the negative input, and channel bit 1 swaps them. The code is 000h when the positive input is less than or equal to the negative input.
- R8: In pseudo-differential mode, the code is floor((pos − neg) × 4096 / 2^REF_LOG2). It saturates at FFFh once pos − neg reaches the reference minus one LSB.
- R9: Serial clocks after the last result bit drive 0 on data-out, with data-out still driven, until chip select rises.
- R10: Raising chip select at any point in a transaction returns the model to standby with data-out undriven. The next transaction then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data from the controller |
| ch0_val | input | IN_W | Channel 0 level, full reference = 2^REF_LOG2 |
| ch1_val | input | IN_W | Channel 1 level, full reference = 2^REF_LOG2 |
| miso | output | 1 | Serial result data |
| miso_oe | output | 1 | High while data-out is driven |
| dbg_cmd_valid | output | 1 | A full command was decoded |
| dbg_single | output | 1 | Decoded mode bit |
| dbg_chan | output | 1 | Decoded channel bit |

## Verification
The properties assume that each serial-clock phase lasts longer than the synchronizer depth plus two system clocks. Under that assumption every serial edge produces exactly one edge pulse, and no edge is merged with the next. They also assume that chip select and data-in change only while the serial clock is low, so a bit is never captured mid-change. The bench keeps the serial clock at eight system clocks per phase and changes data-in, chip select and the channel words only in the low phase. The one exception is the window test, where a channel word is changed on purpose, still in a low phase, on either side of the capture edge.

// File: rtl/adc_slv_pkg.sv
package adc_slv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HUNT,
      ST_MODE,
      ST_CHAN,
      ST_ACQ,
      ST_SHIFT,
      ST_TAIL
   } seq_state_t;
endpackage

// File: rtl/adc_slv_sync.sv
// Synchronizer chain; STAGES = 0 passes the input straight through.
module adc_slv_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_o = async_i;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= {STAGES{RST_VAL}};
            end else begin
               pipe[0] <= async_i;
               for (int i = 1; i < STAGES; i++) begin
                  pipe[i] <= pipe[i-1];
               end
            end
         end
         assign sync_o = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/adc_slv_frontend.sv
// Brings the serial lines into the clk domain and marks serial clock edges.
module adc_slv_frontend #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic mosi,
   output logic cs_s,
   output logic din_s,
   output logic rise_p,
   output logic fall_p
);
   logic sclk_s;
   logic sclk_q;

   adc_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
      .clk(clk), .rst_n(rst_n), .async_i(cs_n), .sync_o(cs_s));
   adc_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ck (
      .clk(clk), .rst_n(rst_n), .async_i(sclk), .sync_o(sclk_s));
   adc_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_di (
      .clk(clk), .rst_n(rst_n), .async_i(mosi), .sync_o(din_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign rise_p = sclk_s & ~sclk_q;
   assign fall_p = ~sclk_s & sclk_q;
endmodule

// File: rtl/adc_slv_conv.sv
// Turns the channel words into a clamped output code.
module adc_slv_conv #(
   parameter int IN_W     = 16,
   parameter int REF_LOG2 = 15,
   parameter int CODE_W   = 12
) (
   input  logic [IN_W-1:0]   ch0_i,
   input  logic [IN_W-1:0]   ch1_i,
   input  logic              single_i,
   input  logic              chan_i,
   output logic [CODE_W-1:0] code_o
);
   localparam int SHIFT = REF_LOG2 - CODE_W;

   logic [IN_W-1:0] pos_v;
   logic [IN_W-1:0] neg_v;
   logic [IN_W-1:0] diff_v;
   logic [IN_W-1:0] scaled_v;
   logic            above_v;
   logic            over_v;

   always_comb begin
      pos_v    = chan_i ? ch1_i : ch0_i;
      neg_v    = single_i ? '0 : (chan_i ? ch0_i : ch1_i);
      above_v  = pos_v > neg_v;
      diff_v   = pos_v - neg_v;
      scaled_v = diff_v >> SHIFT;
      // Scaled values at or beyond 2^CODE_W are past full scale.
      over_v   = |scaled_v[IN_W-1:CODE_W];
      if (!above_v)     code_o = '0;
      else if (over_v)  code_o = '1;
      else              code_o = scaled_v[CODE_W-1:0];
   end
endmodule

// File: rtl/adc_slv_seq.sv
// Command decode, acquisition timing and result shifting.
module adc_slv_seq
   import adc_slv_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              din_s,
   input  logic              rise_p,
   input  logic              fall_p,
   input  logic [CODE_W-1:0] code_i,
   output logic              miso_o,
   output logic              oe_o,
   output logic              single_o,
   output logic              chan_o,
   output logic              cmd_valid_o,
   output seq_state_t        state_o
);
   localparam int CNT_W = $clog2(CODE_W + 1);

   seq_state_t        state;
   logic [CODE_W-1:0] shreg;
   logic [CNT_W-1:0]  bits_left;
   logic              acq_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         shreg       <= '0;
         bits_left   <= '0;
         acq_rise    <= 1'b0;
         miso_o      <= 1'b0;
         oe_o        <= 1'b0;
         single_o    <= 1'b0;
         chan_o      <= 1'b0;
         cmd_valid_o <= 1'b0;
      end else if (cs_s) begin
         state  <= ST_IDLE;
         miso_o <= 1'b0;
         oe_o   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               cmd_valid_o <= 1'b0;
               state       <= ST_HUNT;
            end
            ST_HUNT: begin
               if (rise_p && din_s) state <= ST_MODE;
            end
            ST_MODE: begin
               if (rise_p) begin
                  single_o <= din_s;
                  state    <= ST_CHAN;
               end
            end
            ST_CHAN: begin
               if (rise_p) begin
                  chan_o      <= din_s;
                  cmd_valid_o <= 1'b1;
                  acq_rise    <= 1'b0;
                  state       <= ST_ACQ;
               end
            end
            ST_ACQ: begin
               if (rise_p) begin
                  acq_rise <= 1'b1;
               end else if (fall_p && acq_rise) begin
                  shreg     <= code_i;
                  miso_o    <= 1'b0;
                  oe_o      <= 1'b1;
                  bits_left <= CNT_W'(CODE_W);
                  state     <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (fall_p) begin
                  miso_o    <= shreg[CODE_W-1];
                  shreg     <= {shreg[CODE_W-2:0], 1'b0};
                  bits_left <= bits_left - 1'b1;
                  if (bits_left == CNT_W'(1)) state <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (fall_p) miso_o <= 1'b0;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state;
endmodule

// File: rtl/adc_slave_model.sv
module adc_slave_model
   import adc_slv_pkg::*;
#(
   parameter int IN_W        = 16,
   parameter int REF_LOG2    = 15,
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            sclk,
   input  logic            mosi,
   input  logic [IN_W-1:0] ch0_val,
   input  logic [IN_W-1:0] ch1_val,
   output logic            miso,
   output logic            miso_oe,
   output logic            dbg_cmd_valid,
   output logic            dbg_single,
   output logic            dbg_chan
);
   generate
      if (CODE_W < 2) begin : g_bad_code
         $error("CODE_W must be at least 2");
      end
      if (REF_LOG2 < CODE_W) begin : g_bad_ref
         $error("REF_LOG2 must not be below CODE_W");
      end
      if (IN_W <= REF_LOG2) begin : g_bad_in
         $error("IN_W must exceed REF_LOG2 to allow over-range inputs");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be non-negative");
      end
   endgenerate

   logic              cs_s;
   logic              din_s;
   logic              rise_p;
   logic              fall_p;
   logic [CODE_W-1:0] code;
   seq_state_t        seq_state;

   adc_slv_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
      .cs_s(cs_s), .din_s(din_s), .rise_p(rise_p), .fall_p(fall_p));

   adc_slv_conv #(.IN_W(IN_W), .REF_LOG2(REF_LOG2), .CODE_W(CODE_W)) u_conv (
      .ch0_i(ch0_val), .ch1_i(ch1_val), .single_i(dbg_single),
      .chan_i(dbg_chan), .code_o(code));

   adc_slv_seq #(.CODE_W(CODE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .din_s(din_s),
      .rise_p(rise_p), .fall_p(fall_p), .code_i(code),
      .miso_o(miso), .oe_o(miso_oe), .single_o(dbg_single),
      .chan_o(dbg_chan), .cmd_valid_o(dbg_cmd_valid), .state_o(seq_state));
endmodule

// File: rtl/adc_slave_model_chk.sv
module adc_slave_model_chk
   import adc_slv_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cs_s,
   input logic       fall_p,
   input logic       miso,
   input logic       miso_oe,
   input logic       dbg_cmd_valid,
   input logic       dbg_single,
   input logic       dbg_chan,
   input seq_state_t seq_state
);
   // R1: synchronized chip select high leaves data-out undriven
   a_r1_idle_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !miso_oe);

   // R2: driven data-out only moves right after a falling-edge pulse
   a_r2_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (miso_oe && $past(miso_oe) && (miso != $past(miso))) |-> $past(fall_p));

   // R3: decoded command bits hold while reported valid
   a_r3_cmd_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_cmd_valid && $past(dbg_cmd_valid)) |-> ($stable(dbg_single) && $stable(dbg_chan)));

   // R5: the first driven bit is the null bit
   a_r5_null_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miso_oe) |-> !miso);

   // R9: a falling edge in the tail phase yields a low data-out
   a_r9_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(seq_state == ST_TAIL) && $past(fall_p)) |-> !miso);

   // R10: chip select rising sends the sequencer to standby
   a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_s) |=> ((seq_state == ST_IDLE) && !miso_oe));
endmodule

bind adc_slave_model adc_slave_model_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall_p(fall_p), .miso(miso),
   .miso_oe(miso_oe), .dbg_cmd_valid(dbg_cmd_valid), .dbg_single(dbg_single),
   .dbg_chan(dbg_chan), .seq_state(seq_state));

// File: tb/adc_slave_model_bench.sv
`timescale 1ns/1ps
module adc_slave_model_bench;
   localparam int HALF = 8;
   localparam int NVEC = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        mosi = 1'b0;
   logic [15:0] ch0_val = '0;
   logic [15:0] ch1_val = '0;
   logic        miso, miso_oe, dbg_cmd_valid, dbg_single, dbg_chan;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   adc_slave_model u_adc_slave_model (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
      .ch0_val(ch0_val), .ch1_val(ch1_val), .miso(miso), .miso_oe(miso_oe),
      .dbg_cmd_valid(dbg_cmd_valid), .dbg_single(dbg_single), .dbg_chan(dbg_chan));

   // {single, chan, ch0, ch1, expected code}; reference = 32768, LSB = 8
   localparam logic [45:0] VECS [NVEC] = '{
      {1'b1, 1'b0, 16'd0,     16'd0,     12'h000},
      {1'b1, 1'b0, 16'd1000,  16'd0,     12'h07D},
      {1'b1, 1'b1, 16'd999,   16'd12345, 12'h607},
      {1'b1, 1'b0, 16'd32760, 16'd0,     12'hFFF},
      {1'b1, 1'b1, 16'd0,     16'd40000, 12'hFFF},
      {1'b1, 1'b0, 16'd7,     16'd0,     12'h000},
      {1'b1, 1'b0, 16'd21845, 16'd0,     12'hAAA},
      {1'b0, 1'b0, 16'd5000,  16'd1000,  12'h1F4},
      {1'b0, 1'b0, 16'd1000,  16'd1000,  12'h000},
      {1'b0, 1'b0, 16'd900,   16'd1000,  12'h000},
      {1'b0, 1'b1, 16'd1000,  16'd5000,  12'h1F4},
      {1'b0, 1'b1, 16'd5000,  16'd1000,  12'h000},
      {1'b0, 1'b0, 16'd33760, 16'd1000,  12'hFFF},
      {1'b0, 1'b0, 16'd65535, 16'd100,   12'hFFF},
      {1'b0, 1'b0, 16'd33759, 16'd1000,  12'hFFE}
   };

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One serial clock: high phase then low phase; hi_val is miso late in the high phase.
   task automatic pulse(output logic hi_val);
      sclk = 1'b1;
      wait_clks(HALF);
      hi_val = miso;
      sclk = 1'b0;
      wait_clks(HALF);
   endtask

   task automatic xfer(input logic single, input logic chan,
                       input logic [15:0] a0, input logic [15:0] a1,
                       input logic [15:0] mid0, input logic [15:0] late0,
                       input int lead,
                       output logic [11:0] code, output logic null_b,
                       output logic tail_b, output logic oe_b,
                       output logic hi_ok);
      logic hv;
      logic prev;
      ch0_val = a0; ch1_val = a1;
      cs_n = 1'b0;
      wait_clks(HALF);
      for (int i = 0; i < lead; i++) begin mosi = 1'b0; pulse(hv); end
      mosi = 1'b1;   pulse(hv);
      mosi = single; pulse(hv);
      mosi = chan;   pulse(hv);
      ch0_val = mid0;          // inside acquisition window
      mosi = 1'b0;   pulse(hv);
      null_b = miso;
      oe_b = miso_oe;
      ch0_val = late0;         // after capture
      code = '0;
      hi_ok = 1'b1;
      prev = miso;
      for (int b = 0; b < 12; b++) begin
         pulse(hv);
         if (hv !== prev) hi_ok = 1'b0;
         code = {code[10:0], miso};
         prev = miso;
      end
      pulse(hv);
      if (hv !== prev) hi_ok = 1'b0;
      tail_b = miso;
      oe_b = oe_b & miso_oe;
      pulse(hv);
      tail_b = tail_b | miso;
      oe_b = oe_b & miso_oe;
      cs_n = 1'b1;
      wait_clks(HALF);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [11:0] code;
      logic nb, tb_, oe, hok;
      string tag;
      wait_clks(4);
      // R1: reset state
      check("R1 reset oe", int'(miso_oe), 0);
      check("R1 reset miso", int'(miso), 0);
      check("R1 reset cmd_valid", int'(dbg_cmd_valid), 0);
      rst_n = 1'b1;
      wait_clks(6);
      check("R1 idle oe", int'(miso_oe), 0);

      for (int v = 0; v < NVEC; v++) begin
         logic s, c;
         logic [15:0] a0, a1;
         logic [11:0] ex;
         {s, c, a0, a1, ex} = VECS[v];
         xfer(s, c, a0, a1, a0, a0, 1, code, nb, tb_, oe, hok);
         if (s) tag = "R6 single-ended code";
         else if (ex == 12'h000) tag = "R7 diff floor code";
         else tag = "R8 diff scale/saturate code";
         check(tag, int'(code), int'(ex));
         check("R5 null bit", int'(nb), 0);
         check("R5 driven during result", int'(oe), 1);
         check("R9 tail low", int'(tb_), 0);
         check("R2 stable in high phase", int'(hok), 1);
         check("R3 mode bit", int'(dbg_single), int'(s));
         check("R3 channel bit", int'(dbg_chan), int'(c));
         check("R3 cmd valid", int'(dbg_cmd_valid), 1);
         check("R1 undriven after cs high", int'(miso_oe), 0);
      end

      // R4: change before capture is used, change after capture ignored
      xfer(1'b1, 1'b0, 16'd800, 16'd0, 16'd1600, 16'd4000, 1, code, nb, tb_, oe, hok);
      check("R4 capture at window end", int'(code), 12'h0C8);

      // R3: several leading zeros before the start bit
      xfer(1'b0, 1'b1, 16'd400, 16'd2000, 16'd400, 16'd400, 3, code, nb, tb_, oe, hok);
      check("R3 hunt past zeros code", int'(code), 12'h0C8);
      check("R3 hunt mode bit", int'(dbg_single), 0);
      check("R3 hunt channel bit", int'(dbg_chan), 1);

      // R10: abort mid-result, then a clean transaction
      begin
         logic hv;
         ch0_val = 16'd21845;
         cs_n = 1'b0; wait_clks(HALF);
         mosi = 1'b1; pulse(hv);
         mosi = 1'b1; pulse(hv);
         mosi = 1'b0; pulse(hv);
         mosi = 1'b0; pulse(hv);
         for (int i = 0; i < 5; i++) pulse(hv);
         check("R10 driven before abort", int'(miso_oe), 1);
         cs_n = 1'b1;
         wait_clks(HALF);
         check("R10 abort undriven", int'(miso_oe), 0);
         check("R10 abort miso low", int'(miso), 0);
      end
      xfer(1'b1, 1'b0, 16'd21845, 16'd0, 16'd21845, 16'd21845, 1, code, nb, tb_, oe, hok);
      check("R10 next transaction code", int'(code), 12'hAAA);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule